// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects the interrupt events of a USB On-The-Go controller core into one interrupt request. Events arrive as single-cycle pulses from the protocol engine, the transceiver logic and the DMA. Each pulse is held in a sticky flag. The flags sit in three groups: an error group, a status group and an OTG group. Each group has a flag register and an enable register, and both can be reached through a small register port. A flag is cleared by writing a 1 to its bit.

The error group is not wired to the output directly. It is reduced to one read-only summary bit inside the status group. The output request is registered. It is high when any enabled status flag or enabled OTG flag is set, the summary bit included. A host-mode input decides which event drives two bit positions that have two meanings: end-of-frame error versus CRC5 error, and detach versus bus reset.

Top module: `usb_irq_funnel`

## Requirements
- R1: An event pulse sets its flag whether or not the matching enable bit is set. Flag registers are read at address 0 (status), 2 (error) and 4 (OTG).
- R2: Writing a 1 to a flag bit clears that flag. Writing a 0 leaves the flag unchanged.
- R3: When an event pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R4: The enable registers are plain read/write storage at address 1 (status), 3 (error) and 5 (OTG). They read back the last value written.
- R5: Status bit 1 is the error summary. It reads as the OR of (error flag AND error enable) and is never stored. A write to it has no effect, and it drops only when the underlying error flags or their enables are cleared.
- R6: With host_mode_i high, error bit 1 is set by eof_err_i and status bit 0 is set by detach_i. With host_mode_i low, error bit 1 is set by err_evt_i[1] and status bit 0 is set by stat_evt_i[0]. The other source of each pair is ignored.
- R7: irq_o is registered. It equals the OR over all enabled status flags (summary included) and all enabled OTG flags, as they stood one clock earlier.
- R8: Error bit 4 and OTG bit 1 are reserved. Their flags always read 0, whatever events arrive.
- R9: Reset clears every flag, every enable and irq_o.
- R10: Addresses 6 and 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host role, 0 = device role |
| err_evt_i | input | 8 | Error event pulses: 0 PID, 1 CRC5, 2 CRC16, 3 data size, 4 reserved, 5 turnaround timeout, 6 DMA, 7 bit stuff |
| eof_err_i | input | 1 | End-of-frame error pulse, used in host role |
| stat_evt_i | input | 8 | Status event pulses: 0 bus reset, 1 ignored, 2 SOF, 3 transaction done, 4 idle, 5 resume, 6 attach, 7 stall |
| detach_i | input | 1 | Detach pulse, used in host role |
| otg_evt_i | input | 8 | OTG event pulses: 0 VBUS valid, 1 reserved, 2 session end, 3 session valid, 4 activity, 5 line state stable, 6 1 ms tick, 7 ID change |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from reg_addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An event pulse and a software write-1 clear can land on the same flag in the same clock edge. In that case the event must win, so that no event is lost. The bench provokes this by driving a detach/reset pulse and a clear of that same bit in one cycle. It then reads the status flags back, expecting the bit still set, and clears it again afterwards. The bench also times the summary path: an error-enable write is followed by an idle cycle, and irq_o is checked only after that cycle, because the request register adds one clock.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ERR_FLAG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ERR_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_OTG_FLAG  = 3'd4;
  localparam logic [ADDR_W-1:0] A_OTG_EN    = 3'd5;

  localparam int STAT_RST_BIT = 0;
  localparam int STAT_SUM_BIT = 1;
  localparam int ERR_CRC_BIT  = 1;

  // implemented (settable) flag bits per group
  localparam logic [REG_W-1:0] ERR_IMPL  = 8'hEF;
  localparam logic [REG_W-1:0] STAT_IMPL = 8'hFD;
  localparam logic [REG_W-1:0] OTG_IMPL  = 8'hFD;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int          W    = 8,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         en_we_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] flag_o,
  output logic [W-1:0] en_o
);
  logic [W-1:0] flag_q, en_q;

  // clear first, then set: set wins on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= ((flag_q & ~clr_i) | set_i) & IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_req_stage.sv
module irq_req_stage #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pend_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |pend_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_funnel.sv
module usb_irq_funnel
  import usb_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_mode_i,
  input  logic [REG_W-1:0]  err_evt_i,
  input  logic              eof_err_i,
  input  logic [REG_W-1:0]  stat_evt_i,
  input  logic              detach_i,
  input  logic [REG_W-1:0]  otg_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0] err_set, stat_set, otg_set;
  logic [REG_W-1:0] err_flags, err_en, stat_flags, stat_en, otg_flags, otg_en;
  logic [REG_W-1:0] stat_view;
  logic             err_sum;
  logic [1:0]       pend;

  // role-dependent source on shared bits
  always_comb begin
    err_set  = err_evt_i & ERR_IMPL;
    stat_set = stat_evt_i & STAT_IMPL;
    otg_set  = otg_evt_i & OTG_IMPL;
    err_set[ERR_CRC_BIT]   = host_mode_i ? eof_err_i : err_evt_i[ERR_CRC_BIT];
    stat_set[STAT_RST_BIT] = host_mode_i ? detach_i  : stat_evt_i[STAT_RST_BIT];
  end

  function automatic logic [REG_W-1:0] clr_for(logic [ADDR_W-1:0] a);
    return (reg_we_i && reg_addr_i == a) ? reg_wdata_i : '0;
  endfunction

  irq_flag_bank #(.W(REG_W), .IMPL(ERR_IMPL)) u_err (
    .clk_i, .rst_ni, .set_i(err_set), .clr_i(clr_for(A_ERR_FLAG)),
    .en_we_i(reg_we_i && reg_addr_i == A_ERR_EN), .en_wdata_i(reg_wdata_i),
    .flag_o(err_flags), .en_o(err_en));

  irq_flag_bank #(.W(REG_W), .IMPL(STAT_IMPL)) u_stat (
    .clk_i, .rst_ni, .set_i(stat_set), .clr_i(clr_for(A_STAT_FLAG)),
    .en_we_i(reg_we_i && reg_addr_i == A_STAT_EN), .en_wdata_i(reg_wdata_i),
    .flag_o(stat_flags), .en_o(stat_en));

  irq_flag_bank #(.W(REG_W), .IMPL(OTG_IMPL)) u_otg (
    .clk_i, .rst_ni, .set_i(otg_set), .clr_i(clr_for(A_OTG_FLAG)),
    .en_we_i(reg_we_i && reg_addr_i == A_OTG_EN), .en_wdata_i(reg_wdata_i),
    .flag_o(otg_flags), .en_o(otg_en));

  assign err_sum = |(err_flags & err_en);

  always_comb begin
    stat_view = stat_flags;
    stat_view[STAT_SUM_BIT] = err_sum;
  end

  assign pend = {|(otg_flags & otg_en), |(stat_view & stat_en)};

  irq_req_stage #(.N(2)) u_req (
    .clk_i, .rst_ni, .pend_i(pend), .irq_o);

  always_comb begin
    unique case (reg_addr_i)
      A_STAT_FLAG: reg_rdata_o = stat_view;
      A_STAT_EN:   reg_rdata_o = stat_en;
      A_ERR_FLAG:  reg_rdata_o = err_flags;
      A_ERR_EN:    reg_rdata_o = err_en;
      A_OTG_FLAG:  reg_rdata_o = otg_flags;
      A_OTG_EN:    reg_rdata_o = otg_en;
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/usb_irq_funnel_sva.sv
module usb_irq_funnel_sva
  import usb_irq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              irq_o,
  input logic [REG_W-1:0]  err_set,
  input logic [REG_W-1:0]  stat_set,
  input logic [REG_W-1:0]  err_flags,
  input logic [REG_W-1:0]  err_en,
  input logic [REG_W-1:0]  stat_flags,
  input logic [REG_W-1:0]  stat_view,
  input logic [REG_W-1:0]  stat_en,
  input logic [REG_W-1:0]  otg_flags,
  input logic [REG_W-1:0]  otg_en
);
  // R1 / R3: a pulse always leaves its flag set
  p_set_sticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_set != '0) |=> ((stat_flags & $past(stat_set)) == $past(stat_set)));

  // R2: write-1 clear with no concurrent event
  p_w1c_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_ERR_FLAG && err_set == '0)
    |=> (err_flags == ($past(err_flags) & ~$past(reg_wdata_i))));

  // R4: enables change only on their own write
  p_en_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == A_ERR_EN) |=> $stable(err_en));

  // R5: summary cannot stand without an error flag
  p_sum_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flags == '0) |-> !stat_view[STAT_SUM_BIT]);

  // R7: request follows enabled flags one clock later
  p_irq_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(stat_view & stat_en) || |(otg_flags & otg_en))));

  // R8: reserved flags stay clear
  p_rsvd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_flags[4] && !otg_flags[1]);
endmodule

bind usb_irq_funnel usb_irq_funnel_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .err_set(err_set), .stat_set(stat_set),
  .err_flags(err_flags), .err_en(err_en), .stat_flags(stat_flags),
  .stat_view(stat_view), .stat_en(stat_en), .otg_flags(otg_flags), .otg_en(otg_en));

// File: tb/usb_irq_funnel_test.sv
module usb_irq_funnel_test;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       host, eof, det, we;
  logic [7:0] err_evt, stat_evt, otg_evt, wdata, rdata;
  logic [2:0] addr;
  logic       irq;
  int         errors = 0, checks = 0;

  always #5 clk = ~clk;

  usb_irq_funnel uut (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host), .err_evt_i(err_evt),
    .eof_err_i(eof), .stat_evt_i(stat_evt), .detach_i(det), .otg_evt_i(otg_evt),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq));

  typedef struct packed {
    logic       we;
    logic [2:0] addr;
    logic [7:0] wdata;
    logic [7:0] err;
    logic [7:0] stat;
    logic [7:0] otg;
    logic       host;
    logic       eof;
    logic       det;
    logic [2:0] chk;
    logic [7:0] exp_rd;
    logic       exp_irq;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 23;
  localparam step_t TBL [NSTEP] = '{
    '{0,3'd0,8'h00,8'h00,8'h04,8'h00,0,0,0,3'd0,8'h04,0,4'd1},  // R1 SOF without enable
    '{1,3'd1,8'h04,8'h00,8'h00,8'h00,0,0,0,3'd1,8'h04,1,4'd4},  // R4 R7
    '{1,3'd0,8'h00,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h04,1,4'd2},  // R2 write 0
    '{1,3'd0,8'h04,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h00,0,4'd2},  // R2 write 1
    '{0,3'd0,8'h00,8'h91,8'h00,8'h00,0,0,0,3'd2,8'h81,0,4'd8},  // R8 reserved err bit
    '{1,3'd3,8'h01,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h02,0,4'd5},  // R5 summary
    '{1,3'd1,8'h06,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h02,1,4'd7},  // R7 via summary
    '{1,3'd0,8'h02,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h02,1,4'd5},  // R5 write ignored
    '{1,3'd2,8'h01,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h00,0,4'd5},  // R5 drops with source
    '{0,3'd0,8'h00,8'h00,8'h00,8'h00,0,1,0,3'd2,8'h80,0,4'd6},  // R6 eof ignored in device
    '{0,3'd0,8'h00,8'h02,8'h00,8'h00,0,0,0,3'd2,8'h82,0,4'd6},  // R6 crc5 in device
    '{1,3'd2,8'hFF,8'h00,8'h00,8'h00,0,0,0,3'd2,8'h00,0,4'd2},
    '{0,3'd0,8'h00,8'h02,8'h00,8'h00,1,0,0,3'd2,8'h00,0,4'd6},  // R6 crc5 ignored in host
    '{0,3'd0,8'h00,8'h00,8'h00,8'h00,1,1,0,3'd2,8'h02,0,4'd6},  // R6 eof in host
    '{0,3'd0,8'h00,8'h00,8'h01,8'h00,1,0,0,3'd0,8'h00,0,4'd6},  // R6 reset ignored in host
    '{0,3'd0,8'h00,8'h00,8'h00,8'h00,1,0,1,3'd0,8'h01,0,4'd6},  // R6 detach in host
    '{1,3'd0,8'h01,8'h00,8'h01,8'h00,0,0,0,3'd0,8'h01,0,4'd3},  // R3 set wins
    '{1,3'd0,8'h01,8'h00,8'h00,8'h00,0,0,0,3'd0,8'h00,0,4'd2},
    '{0,3'd0,8'h00,8'h00,8'h00,8'h82,0,0,0,3'd4,8'h80,0,4'd8},  // R8 reserved otg bit
    '{1,3'd5,8'h80,8'h00,8'h00,8'h00,0,0,0,3'd5,8'h80,1,4'd7},  // R7 otg path
    '{1,3'd4,8'h80,8'h00,8'h00,8'h00,0,0,0,3'd4,8'h00,0,4'd2},
    '{1,3'd6,8'hFF,8'h00,8'h00,8'h00,0,0,0,3'd6,8'h00,0,4'd10}, // R10 unmapped
    '{1,3'd3,8'hFF,8'h00,8'h00,8'h00,0,0,0,3'd3,8'hFF,1,4'd5}   // R5 summary re-raised by enable
  };

  task automatic idle();
    we = 0; addr = 0; wdata = 0; err_evt = 0; stat_evt = 0; otg_evt = 0;
    eof = 0; det = 0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    host = 0; idle();
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1 check("R9 reset reg", rdata, 8'h00);
    end
    check("R9 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1;

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      we = TBL[i].we; addr = TBL[i].addr; wdata = TBL[i].wdata;
      err_evt = TBL[i].err; stat_evt = TBL[i].stat; otg_evt = TBL[i].otg;
      host = TBL[i].host; eof = TBL[i].eof; det = TBL[i].det;
      @(negedge clk); idle(); host = 0;
      @(negedge clk); addr = TBL[i].chk; #1;
      check($sformatf("R%0d step %0d rdata", TBL[i].req, i), rdata, TBL[i].exp_rd);
      check($sformatf("R%0d step %0d irq", TBL[i].req, i), {7'd0, irq}, {7'd0, TBL[i].exp_irq});
    end

    // R7 latency: clear error flags, then pulse SOF (enabled)
    @(negedge clk); we = 1; addr = 3'd2; wdata = 8'hFF;
    @(negedge clk); idle();
    @(negedge clk); #1 check("R7 idle before pulse", {7'd0, irq}, 8'h00);
    stat_evt = 8'h04;
    @(negedge clk); idle(); #1 check("R7 not yet after flag edge", {7'd0, irq}, 8'h00);
    @(negedge clk); #1 check("R7 one clock later", {7'd0, irq}, 8'h01);

    // R9 reset mid-run clears enables and request
    rst_n = 0; #1;
    addr = 3'd3; #1 check("R9 enable cleared", rdata, 8'h00);
    check("R9 irq cleared", {7'd0, irq}, 8'h00);
    rst_n = 1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule